// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (clock line plus open-drain data line) that lets a system controller read and rewrite a small bank of 8-bit configuration registers. Each register drives a parallel output, for example one enable bit per output buffer, and holds its default value from reset. Software does not have to touch the bus at all, because the defaults already give a usable setup.

The slave answers to one 7-bit address. The first byte after a write address is a command code. Its top bit picks either byte access to one indexed register or block access that always starts at register 0. Block writes carry a count byte ahead of the data. Block reads return a count byte ahead of the data. A byte read is a command write, then a repeated START, then the read address. Both bus lines are oversampled in the core clock domain. The data line is driven only as an active-low output enable.

Top module: `smb_cfg_slave`

## Requirements
- R1: While reset is held and right after it is released, every register on regs_o equals its REG_DEFAULTS byte (register i at bits 8i+7..8i) and sda_oe is 0.
- R2: The slave acknowledges only the 7-bit address 0x69, which is the byte 0xD2 for a write and 0xD3 for a read. Any other address gets no acknowledge and changes no register.
- R3: When command bit 7 is 1, bits 6..0 are a register offset. The next data byte is written to that register.
- R4: When command bit 7 is 0, the block mode is selected and bits 6..0 are ignored. The byte after the command is a count, whose value is not used. The data bytes that follow go to registers 0, 1, 2 and so on in that order.
- R5: A block write that the controller ends with STOP after any complete data byte leaves all higher registers unchanged.
- R6: A byte read returns the register selected by the last byte-mode command. It is sent most significant bit first.
- R7: A block read first returns a count byte equal to NUM_REGS (8 by default), then registers 0, 1, 2 and so on, for as long as the controller acknowledges. After the controller's not-acknowledge the slave releases SDA.
- R8: An offset at or above NUM_REGS is not acknowledged on a data write and changes no register. On a read it returns 0x00.
- R9: The slave acknowledges its address, the command byte and each accepted data byte. It only starts driving SDA low while SCL is low.
- R10: A STOP or a new START at any point, including in the middle of a byte, sends the slave back to address reception. A partly received byte is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | NUM_REGS*8 | Register bank contents, register i at bits 8i+7..8i |

## Verification
The bench goes after the block-mode command whose low bits are not zero. A design that used those bits as a start offset would write the wrong register. It checks that the count byte is skipped on writes and sent as the first read byte. Getting that wrong shifts every later register by one place. Offsets beyond the bank must be not-acknowledged and read back as zero; a faulty design would alias them onto a real register. Transfers are aborted both by a repeated START and by a STOP in the middle of a byte. A design that kept a half-shifted byte would corrupt a register, and one that missed the condition would stay hung and not answer the next transfer.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned OFFSET_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_prev_q, sda_prev_q;
  logic scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

  // R10: at most one bus event is reported per cycle
  a_r10_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_det, stop_det}));
endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
  import smb_cfg_pkg::*;
#(
  parameter int unsigned              NUM_REGS     = 8,
  parameter logic [NUM_REGS*8-1:0]    REG_DEFAULTS = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [OFFSET_W-1:0]        idx,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [BYTE_W-1:0]          rd_data,
  output logic                       idx_hit,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cell_q <= REG_DEFAULTS[g*BYTE_W +: BYTE_W];
      else if (wr_en && idx == OFFSET_W'(g))    cell_q <= wr_data;
    end
    assign regs_o[g*BYTE_W +: BYTE_W] = cell_q;
  end

  assign idx_hit = (idx < OFFSET_W'(NUM_REGS));

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == OFFSET_W'(i)) rd_data = regs_o[i*BYTE_W +: BYTE_W];
  end

  // R5: registers only move on a write strobe
  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int unsigned           NUM_REGS     = 8,
  parameter logic [6:0]            DEV_ADDR     = 7'h69,
  parameter int unsigned           SYNC_STAGES  = 2,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 64'hE1D2C3B4A5968778
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam logic [3:0]        FULL_BYTE = 4'(BYTE_W);
  localparam logic [BYTE_W-1:0] COUNT_VAL = BYTE_W'(NUM_REGS);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
  );

  slv_state_e          state_q, state_d;
  logic [3:0]          bit_cnt_q, bit_cnt_d;
  logic                ack_ph_q, ack_ph_d;
  logic                rw_q, rw_d;
  logic                cnt_next_q, cnt_next_d;
  logic                mack_q, mack_d;
  logic                sda_oe_q, sda_oe_d;
  logic [BYTE_W-1:0]   shreg_q, shreg_d;
  logic [BYTE_W-1:0]   txsh_q, txsh_d;
  logic [OFFSET_W-1:0] ptr_q, ptr_d;

  logic                wr_en, idx_hit;
  logic [BYTE_W-1:0]   rd_data, tx_byte;

  smb_cfg_bank #(.NUM_REGS(NUM_REGS), .REG_DEFAULTS(REG_DEFAULTS)) u_bank (
    .clk, .rst_n, .wr_en, .idx(ptr_q), .wr_data(shreg_q),
    .rd_data, .idx_hit, .regs_o
  );

  assign tx_byte = cnt_next_q ? COUNT_VAL : rd_data;

  always_comb begin
    state_d    = state_q;
    bit_cnt_d  = bit_cnt_q;
    ack_ph_d   = ack_ph_q;
    rw_d       = rw_q;
    cnt_next_d = cnt_next_q;
    mack_d     = mack_q;
    sda_oe_d   = sda_oe_q;
    shreg_d    = shreg_q;
    txsh_d     = txsh_q;
    ptr_d      = ptr_q;
    wr_en      = 1'b0;
    if (start_det || stop_det) begin
      state_d   = start_det ? ST_ADDR : ST_IDLE;
      bit_cnt_d = '0;
      ack_ph_d  = 1'b0;
      sda_oe_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise && !ack_ph_q && bit_cnt_q < FULL_BYTE) begin
            shreg_d   = {shreg_q[BYTE_W-2:0], sda_s};
            bit_cnt_d = bit_cnt_q + 4'd1;
          end else if (scl_fall && !ack_ph_q && bit_cnt_q == FULL_BYTE) begin
            ack_ph_d = 1'b1;
            sda_oe_d = 1'b1;
            if (state_q == ST_ADDR) begin
              rw_d = shreg_q[0];
              if (shreg_q[7:1] != DEV_ADDR) begin
                state_d  = ST_SKIP;
                sda_oe_d = 1'b0;
              end
            end else if (state_q == ST_CMD) begin
              cnt_next_d = ~shreg_q[7];
              ptr_d      = shreg_q[7] ? shreg_q[OFFSET_W-1:0] : '0;
            end else if (cnt_next_q) begin
              cnt_next_d = 1'b0;
            end else if (idx_hit) begin
              wr_en = 1'b1;
              ptr_d = ptr_q + 1'b1;
            end else begin
              state_d  = ST_SKIP;
              sda_oe_d = 1'b0;
            end
          end else if (scl_fall && ack_ph_q) begin
            ack_ph_d  = 1'b0;
            bit_cnt_d = '0;
            sda_oe_d  = 1'b0;
            if (state_q == ST_ADDR && rw_q) begin
              state_d  = ST_RD;
              txsh_d   = tx_byte;
              sda_oe_d = ~tx_byte[7];
            end else begin
              state_d = (state_q == ST_ADDR) ? ST_CMD : ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            if (ack_ph_q)                     mack_d = ~sda_s;
            else if (bit_cnt_q < FULL_BYTE)   bit_cnt_d = bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (!ack_ph_q && bit_cnt_q == FULL_BYTE) begin
              sda_oe_d = 1'b0;
              ack_ph_d = 1'b1;
              if (cnt_next_q) cnt_next_d = 1'b0;
              else            ptr_d      = ptr_q + 1'b1;
            end else if (!ack_ph_q && bit_cnt_q != '0) begin
              txsh_d   = {txsh_q[BYTE_W-2:0], 1'b0};
              sda_oe_d = ~txsh_q[BYTE_W-2];
            end else if (ack_ph_q) begin
              ack_ph_d = 1'b0;
              if (mack_q) begin
                txsh_d    = tx_byte;
                sda_oe_d  = ~tx_byte[7];
                bit_cnt_d = '0;
              end else begin
                state_d = ST_SKIP;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      ack_ph_q   <= 1'b0;
      rw_q       <= 1'b0;
      cnt_next_q <= 1'b1;
      mack_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
      shreg_q    <= '0;
      txsh_q     <= '0;
      ptr_q      <= '0;
    end else begin
      state_q    <= state_d;
      bit_cnt_q  <= bit_cnt_d;
      ack_ph_q   <= ack_ph_d;
      rw_q       <= rw_d;
      cnt_next_q <= cnt_next_d;
      mack_q     <= mack_d;
      sda_oe_q   <= sda_oe_d;
      shreg_q    <= shreg_d;
      txsh_q     <= txsh_d;
      ptr_q      <= ptr_d;
    end
  end

  assign sda_oe = sda_oe_q;

  // R1: an idle slave never holds the data line
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe);
  // R9: the line is only pulled low right after a falling clock edge
  a_r9_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R8: a write never targets an offset outside the bank
  a_r8_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> idx_hit);
  // R10: a STOP always lands in idle
  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE));
endmodule

// File: tb/tb_smb_cfg_slave.sv
module tb_smb_cfg_slave;
  localparam int Q = 10;
  localparam logic [63:0] DEFS = 64'hE1D2C3B4A5968778;

  logic clk = 1'b0;
  logic rst_n;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [63:0] regs_o;
  logic sda_line;

  assign sda_line = ~(m_low | sda_oe);

  always #2 clk = ~clk;

  smb_cfg_slave dut (
    .clk, .rst_n, .scl_i(scl), .sda_i(sda_line), .sda_oe, .regs_o
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [8];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] rx_val;
  event       rx_ev;
  bit         done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_vec();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
    end
    tick(Q); m_low = !nack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q); m_low = 1'b0;
    rx_val = b;
    -> rx_ev;
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: pops one expected item per received byte
  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected byte", 64'(rx_val), 64'h0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rx_val == e, t, 64'(rx_val), 64'(e));
      end
    end
  end

  task automatic byte_write(input logic [7:0] off, input logic [7:0] d, input bit exp_dack, input string tag);
    logic a;
    bus_start();
    send_byte(8'hD2, a); check(a == 1'b1, "R9 address ack", 64'(a), 64'h1);
    send_byte(8'h80 | off, a); check(a == 1'b1, "R9 command ack", 64'(a), 64'h1);
    send_byte(d, a); check(a == exp_dack, tag, 64'(a), 64'(exp_dack));
    bus_stop();
  endtask

  task automatic byte_read(input logic [7:0] off, input logic [7:0] exp, input string tag);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h80 | off, a);
    bus_rstart();
    send_byte(8'hD3, a); check(a == 1'b1, "R2 read address ack", 64'(a), 64'h1);
    expect_byte(exp, tag);
    recv_byte(1'b1, b);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < 8; i++) model[i] = DEFS[i*8 +: 8];
    rst_n = 1'b0;
    tick(3);
    check(regs_o == DEFS, "R1 defaults during reset", regs_o, DEFS);
    tick(2);
    rst_n = 1'b1;
    tick(4);
    check(regs_o == DEFS, "R1 defaults after reset", regs_o, DEFS);
    check(sda_oe == 1'b0, "R1 sda released", 64'(sda_oe), 64'h0);

    // R3: byte write to offset 3
    byte_write(8'h03, 8'h5A, 1'b1, "R3 data ack");
    model[3] = 8'h5A;
    check(regs_o == model_vec(), "R3 byte write", regs_o, model_vec());

    // R2: foreign address 0x50 (byte 0xA0)
    bus_start();
    send_byte(8'hA0, a); check(a == 1'b0, "R2 foreign address nack", 64'(a), 64'h0);
    send_byte(8'h81, a);
    send_byte(8'hFF, a);
    bus_stop();
    check(regs_o == model_vec(), "R2 foreign address no effect", regs_o, model_vec());

    // R4 R5: block write of three bytes, then STOP
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a); check(a == 1'b1, "R4 block command ack", 64'(a), 64'h1);
    send_byte(8'h03, a); check(a == 1'b1, "R4 count ack", 64'(a), 64'h1);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a); check(a == 1'b1, "R9 block data ack", 64'(a), 64'h1);
    bus_stop();
    model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
    check(regs_o == model_vec(), "R5 block write stops after byte 2", regs_o, model_vec());

    // R4: block command with nonzero low bits still starts at register 0
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h05, a);
    send_byte(8'h01, a);
    send_byte(8'h44, a);
    bus_stop();
    model[0] = 8'h44;
    check(regs_o == model_vec(), "R4 low command bits ignored", regs_o, model_vec());

    // R8: out-of-range write
    byte_write(8'h09, 8'h77, 1'b0, "R8 out-of-range nack");
    check(regs_o == model_vec(), "R8 out-of-range no write", regs_o, model_vec());

    // R6: byte reads
    byte_read(8'h03, 8'h5A, "R6 byte read offset 3");
    byte_read(8'h07, 8'hE1, "R6 byte read offset 7");

    // R7: block read with count byte then all registers
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    bus_rstart();
    send_byte(8'hD3, a);
    expect_byte(8'h08, "R7 count byte");
    recv_byte(1'b0, b);
    for (int i = 0; i < 8; i++) begin
      expect_byte(model[i], "R7 block read data");
      recv_byte(i == 7, b);
    end
    tick(Q);
    check(sda_oe == 1'b0, "R7 released after nack", 64'(sda_oe), 64'h0);
    bus_stop();

    // R8: out-of-range read
    byte_read(8'h20, 8'h00, "R8 out-of-range read zero");

    // R10: repeated START in the middle of a data byte
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h81, a);
    send_bits(8'h99, 4);
    bus_rstart();
    send_byte(8'hD3, a); check(a == 1'b1, "R10 ack after restart", 64'(a), 64'h1);
    expect_byte(model[1], "R10 partial byte not written");
    recv_byte(1'b1, b);
    bus_stop();
    check(regs_o == model_vec(), "R10 regs after restart abort", regs_o, model_vec());

    // R10: STOP in the middle of a data byte
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h82, a);
    send_bits(8'h3C, 5);
    bus_stop();
    check(regs_o == model_vec(), "R10 regs after stop abort", regs_o, model_vec());
    byte_read(8'h02, 8'h33, "R10 idle after stop abort");

    tick(Q);
    check(exp_q.size() == 0, "R7 scoreboard drained", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule